// File: doc/BRIEF.md
# Per-Lane Case Predication Mask Generator

This block turns a case-style predication prefix into execute-enable masks for every lane of a vectorized loop. The prefix gives a shadow length (how many following instructions it governs) and a test mode. Each lane supplies its own selector value. From these, the block works out which of the shadowed instructions that lane runs. The shadowed instructions stay resident across iterations, so a new prefix is presented on each iteration and a fresh mask set is produced. Nothing is skipped or jumped over.

The mask is registered one cycle after the prefix and selectors are accepted, so the cost is a single extra cycle. A prefix that arrives while a result is still pending replaces it.

Top module: `case_pred_mask`

## Requirements
- R1: After reset, `mask_valid` is 0 and every bit of `lane_mask` is 0.
- R2: When `pfx_valid` is high at a rising edge, `mask_valid` is high in the cycle after that edge. It is high for exactly one cycle for each accepted prefix, and low otherwise.
- R3: Mode ONLY (`pfx_mode`=0): the lane's mask has only bit s set, where s is that lane's selector and s < M. If s >= M, the mask is all zeros.
- R4: Mode UPTO (`pfx_mode`=1): bits 0 through s are set, inclusive of s. If s >= M, all M bits are set.
- R5: Mode EXCEPT (`pfx_mode`=2): all M bits except bit s are set. If s >= M, all M bits are set.
- R6: Mask bits at positions M and above are always 0. The field `pfx_len` encodes M-1, so M ranges from 1 to 8. Mode code 3 yields an all-zero mask.
- R7: Lane k's mask occupies bits [k*8 +: 8] of `lane_mask` and depends only on lane k's selector, held in `lane_sel[k*SEL_W +: SEL_W]`.
- R8: When prefixes arrive on back-to-back cycles, each output set reflects the most recently accepted prefix. Between strobes, `lane_mask` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid | input | 1 | Prefix and selectors present this cycle |
| pfx_len | input | 3 | Shadow length minus one |
| pfx_mode | input | 2 | Test mode: 0 ONLY, 1 UPTO, 2 EXCEPT |
| lane_sel | input | LANES*SEL_W | Per-lane selector values |
| mask_valid | output | 1 | One-cycle strobe for a new mask set |
| lane_mask | output | LANES*8 | Per-lane enable masks, 8 bits per lane |

## Verification
The assertions check on every cycle that the strobe follows each accepted prefix by exactly one cycle. They also check that bits beyond the shadow length stay clear, that an ONLY mask never has more than one bit set, and that the outputs hold steady between strobes. Only the bench's scenarios can show the exact mask per mode. The bench covers selectors at and beyond the shadow length, lanes with different selectors in the same iteration, the single-instruction shadow, and back-to-back prefixes where the later one wins. It does this against a behavioural model compared every cycle.

// File: rtl/case_pred_mask.sv
module case_pred_mask #(
  parameter int LANES = 8,
  parameter int SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pfx_valid,
  input  logic [2:0]             pfx_len,
  input  logic [1:0]             pfx_mode,
  input  logic [LANES*SEL_W-1:0] lane_sel,
  output logic                   mask_valid,
  output logic [LANES*8-1:0]     lane_mask
);
  localparam int MW = 8;

  logic [MW-1:0] len_ones;
  assign len_ones = 8'hFF >> (3'd7 - pfx_len);

  logic [LANES*MW-1:0] next_mask;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEL_W-1:0] sel;
    logic             in_rng;
    logic [MW-1:0]    hot, upto, raw;
    assign sel    = lane_sel[k*SEL_W +: SEL_W];
    assign in_rng = ({{(32-SEL_W){1'b0}}, sel} <= {29'd0, pfx_len});
    assign hot    = in_rng ? (8'd1 << sel[2:0]) : 8'd0;
    assign upto   = in_rng ? ((8'd2 << sel[2:0]) - 8'd1) : 8'hFF;
    always_comb begin
      case (pfx_mode)
        2'd0:    raw = hot;
        2'd1:    raw = upto;
        2'd2:    raw = ~hot;
        default: raw = 8'd0;
      endcase
    end
    assign next_mask[k*MW +: MW] = raw & len_ones;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_valid <= 1'b0;
      lane_mask  <= '0;
    end else begin
      mask_valid <= pfx_valid;
      if (pfx_valid) lane_mask <= next_mask;
    end
  end
endmodule

module case_pred_mask_chk #(
  parameter int LANES = 8,
  parameter int SEL_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   pfx_valid,
  input logic [2:0]             pfx_len,
  input logic [1:0]             pfx_mode,
  input logic [LANES*SEL_W-1:0] lane_sel,
  input logic                   mask_valid,
  input logic [LANES*8-1:0]     lane_mask
);
  // R2
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid |=> mask_valid);
  // R2
  no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_valid |=> !mask_valid);
  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_valid |=> $stable(lane_mask));
  for (genvar k = 0; k < LANES; k++) begin : g_c
    // R6
    beyond_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_valid |=> ((lane_mask[k*8 +: 8] & ~(8'hFF >> (3'd7 - $past(pfx_len)))) == 8'd0));
    // R3
    only_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_valid && pfx_mode == 2'd0) |=> $onehot0(lane_mask[k*8 +: 8]));
  end
endmodule

bind case_pred_mask case_pred_mask_chk #(.LANES(LANES), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_case_pred_mask.sv
module test_case_pred_mask;
  localparam int LANES = 8;
  localparam int SEL_W = 4;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, pfx_valid = 0;
  logic [2:0] pfx_len = 0;
  logic [1:0] pfx_mode = 0;
  logic [LANES*SEL_W-1:0] lane_sel = '0;
  logic mask_valid;
  logic [LANES*8-1:0] lane_mask;

  int checks = 0, errors = 0;
  logic [LANES*8-1:0] exp_mask = '0;
  logic exp_valid = 0;

  case_pred_mask #(.LANES(LANES), .SEL_W(SEL_W)) i_case_pred_mask (.*);

  always #(TCLK/2) clk = ~clk;

  function automatic logic [7:0] model(int m, int mode, int s);
    logic [7:0] r = 0;
    for (int p = 0; p < m; p++) begin
      case (mode)
        0: r[p] = (p == s);
        1: r[p] = (s >= m) || (p <= s);
        2: r[p] = (p != s);
        default: r[p] = 0;
      endcase
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 0; exp_mask <= '0;
    end else begin
      exp_valid <= pfx_valid;
      if (pfx_valid)
        for (int k = 0; k < LANES; k++)
          exp_mask[k*8 +: 8] <= model(pfx_len + 1, pfx_mode, lane_sel[k*SEL_W +: SEL_W]);
    end
  end

  // per-cycle comparison, sampled mid-low phase
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (mask_valid !== exp_valid) begin
      errors++; $display("FAIL R2 mask_valid act=%b exp=%b", mask_valid, exp_valid);
    end
    checks++;
    if (lane_mask !== exp_mask) begin
      errors++; $display("FAIL R3/R4/R5/R6/R7/R8 lane_mask act=%h exp=%h", lane_mask, exp_mask);
    end
  end

  task automatic send(int m, int mode, logic [LANES*SEL_W-1:0] sels);
    @(posedge clk); #1;
    pfx_valid = 1; pfx_len = 3'(m - 1); pfx_mode = 2'(mode); lane_sel = sels;
    @(posedge clk); #1;
    pfx_valid = 0;
  endtask

  function automatic logic [LANES*SEL_W-1:0] ramp(int base);
    logic [LANES*SEL_W-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*SEL_W +: SEL_W] = SEL_W'((base + k) % 16);
    return v;
  endfunction

  initial begin
    #(TCLK*1000);
    errors++; checks++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    checks++;
    if (mask_valid !== 0 || lane_mask !== '0) begin
      errors++; $display("FAIL R1 reset act=%b/%h exp=0/0", mask_valid, lane_mask);
    end
    // R3 ONLY, lanes differ (R7), selectors beyond M
    send(8, 0, ramp(0));
    send(5, 0, ramp(2));
    // R4 UPTO, inclusive and overflow
    send(8, 1, ramp(0));
    send(4, 1, ramp(1));
    // R5 EXCEPT
    send(8, 2, ramp(3));
    send(3, 2, ramp(0));
    // R6 M=1 and mode 3
    send(1, 0, ramp(0));
    send(1, 1, ramp(5));
    send(6, 3, ramp(0));
    // selector 15 in all modes
    for (int md = 0; md < 3; md++) send(8, md, {LANES{4'hF}});
    // R8 back-to-back: later prefix wins, then hold
    @(posedge clk); #1;
    pfx_valid = 1; pfx_len = 7; pfx_mode = 0; lane_sel = ramp(0);
    @(posedge clk); #1;
    pfx_mode = 2; lane_sel = ramp(4);
    @(posedge clk); #1;
    pfx_valid = 0;
    repeat (4) @(posedge clk);
    // sweep
    for (int m = 1; m <= 8; m++)
      for (int md = 0; md < 4; md++) send(m, md, ramp(m * 3 + md));
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule